// File: doc/BRIEF.md
# Boot ROM and Scratch RAM Serial Responder

This block sits on the peripheral side of a bit-serial link. It answers requests that address an 11-bit byte window. The lower part of the window is a boot ROM. The top 64 bytes are a scratch RAM that the host and an external device engine use to exchange data. The host sends a short header that carries an opcode and a word address. The responder then acknowledges and either streams data back or takes in data. Transfers are either one 32-bit word or the whole 512-bit RAM image.

A 64-byte image read is special. The responder holds back its acknowledge until the device engine reports, on a "handshake done" input, that it has finished. While it waits, the engine can rewrite RAM bytes through a side write port, and the image that is returned contains those updates. A lock input hides the ROM once boot is over. Writes aimed at the ROM are acknowledged and then dropped.

Top module: `romram_responder`

## Requirements
- R1: A header is 12 bits sent MSB first, one bit per cycle while `in_valid` is high. It holds a 3-bit opcode followed by a 9-bit word address, which is byte-address bits 10..2; byte-address bits 1..0 are zero. The opcodes are 011 read word, 010 write word, 001 read image and 000 write image.
- R2: Word addresses 0x000–0x1EF decode to ROM. Word addresses 0x1F0–0x1FF decode to RAM word i = addr[3:0], which is RAM bytes 4i..4i+3, with byte 4i in bits 31:24.
- R3: For a word read, `ack` is high for exactly one cycle, in the cycle after the last header bit. In the 32 cycles that follow, `out_valid` is high and `out_bit` carries the word MSB first.
- R4: ROM word i equals ROM_SEED XOR (i × 0x9E3779B9), modulo 2^32, for i < ROM_WORDS. Any other word in the ROM region reads as zero.
- R5: Once `lock_rom` is seen high at a clock edge, every ROM-region read returns zero until reset, even after `lock_rom` falls. RAM reads are not affected.
- R6: For a word write, `ack` pulses once and the host then sends 32 bits MSB first. The RAM word is updated. A write to the ROM region is acknowledged but changes nothing.
- R7: For an image read, `ack` stays low until `hs_done` is high in a cycle while the responder is waiting. `ack` then pulses in the next cycle, and the 512 RAM bits follow, byte 0 first, each byte MSB first.
- R8: When `ext_we` is high, RAM byte `ext_idx` takes the value `ext_byte` at that clock edge.
- R9: For an image write, `ack` pulses and the host then sends 512 bits, byte 0 first, each byte MSB first. Each byte is stored when its eighth bit arrives.
- R10: If a host write and `ext_we` hit the same RAM byte in the same cycle, the host value is stored.
- R11: A header whose opcode MSB is 1 produces no `ack` and no output, and the responder waits for a new header. An `hs_done` pulse outside an image-read wait is ignored.
- R12: After reset, `ack` and `out_valid` are low and all RAM bytes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Host bit strobe |
| in_bit | input | 1 | Host serial bit (header or write data) |
| hs_done | input | 1 | Device engine finished; releases image-read acknowledge |
| lock_rom | input | 1 | Sticky ROM lockout request |
| ext_we | input | 1 | Device engine RAM byte write enable |
| ext_idx | input | 6 | Device engine RAM byte index |
| ext_byte | input | 8 | Device engine RAM byte data |
| ack | output | 1 | One-cycle acknowledge |
| out_valid | output | 1 | Response bit strobe |
| out_bit | output | 1 | Response serial bit |

## Verification
During an image write, the host stores a RAM byte and the device engine's side port can write the same byte in the same clock edge. The bench provokes this by raising `ext_we` for byte 9 with a different value in exactly the cycle that carries that byte's eighth host bit. It then reads the word that holds byte 9 and expects the host's value. It also expects every other byte to hold the host's image. Engine writes made during the image-read wait are judged separately, by comparing the returned image against the bench's own RAM model.

// File: rtl/romram_resp_pkg.sv
// Package: shared opcodes, states and sizes for the serial ROM/RAM responder.
// Assumes a fixed 64-byte RAM at the top of an 11-bit byte window.
package romram_resp_pkg;
    localparam int HDR_W    = 12;
    localparam int WADDR_W  = 9;
    localparam int RAM_BYTES = 64;
    localparam int IMG_BITS = RAM_BYTES * 8;
    localparam int BIDX_W   = $clog2(RAM_BYTES);
    localparam int CNT_W    = $clog2(IMG_BITS);
    localparam logic [4:0] RAM_TAG = 5'b11111;

    typedef enum logic [2:0] {
        OP_WR_IMG  = 3'b000,
        OP_RD_IMG  = 3'b001,
        OP_WR_WORD = 3'b010,
        OP_RD_WORD = 3'b011
    } op_e;

    typedef enum logic [2:0] {
        ST_HDR, ST_WAIT, ST_ACK, ST_TX, ST_RX
    } st_e;
endpackage

// File: rtl/romram_rom.sv
// Boot ROM: a computed constant table with a sticky lockout.
// Assumes 2 <= ROM_WORDS <= 496; words past ROM_WORDS read zero.
module romram_rom
    import romram_resp_pkg::*;
#(
    parameter int          ROM_WORDS = 16,
    parameter logic [31:0] ROM_SEED  = 32'h1357_9BDF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lock_rom,
    input  logic [WADDR_W-1:0] waddr,
    output logic [31:0]        rom_word
);
    localparam int RIW = $clog2(ROM_WORDS);
    localparam logic [WADDR_W-1:0] ROM_LIM = WADDR_W'(ROM_WORDS);

    logic [31:0] tbl [ROM_WORDS];
    logic        locked_q;

    for (genvar i = 0; i < ROM_WORDS; i++) begin : g_tbl
        assign tbl[i] = ROM_SEED ^ (32'(i) * 32'h9E37_79B9);
    end

    // Latch the lockout until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        locked_q <= 1'b0;
        else if (lock_rom) locked_q <= 1'b1;
    end

    // Select the addressed word, or zero when locked or out of range.
    always_comb begin
        if (locked_q || waddr >= ROM_LIM) rom_word = 32'h0;
        else                              rom_word = tbl[waddr[RIW-1:0]];
    end

    // R5
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> locked_q);
    // R5
    locked_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |-> rom_word == 32'h0);
endmodule

// File: rtl/romram_ram.sv
// Scratch RAM: 64 bytes, a host port (byte or word) and a device-engine byte port.
// Assumes the host port takes priority over the engine port on a collision.
module romram_ram
    import romram_resp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_word_en,
    input  logic [3:0]        h_word_idx,
    input  logic [31:0]       h_word,
    input  logic              h_byte_en,
    input  logic [BIDX_W-1:0] h_byte_idx,
    input  logic [7:0]        h_byte,
    input  logic              ext_we,
    input  logic [BIDX_W-1:0] ext_idx,
    input  logic [7:0]        ext_byte,
    input  logic [3:0]        rd_word_idx,
    output logic [31:0]       rd_word,
    input  logic [BIDX_W-1:0] rd_byte_idx,
    output logic [7:0]        rd_byte
);
    logic [7:0] mem [RAM_BYTES];

    // Store writes; the host write is applied last so it wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < RAM_BYTES; b++) mem[b] <= 8'h00;
        end else begin
            if (ext_we)    mem[ext_idx] <= ext_byte;
            if (h_byte_en) mem[h_byte_idx] <= h_byte;
            if (h_word_en) begin
                for (int k = 0; k < 4; k++)
                    mem[{h_word_idx, 2'(k)}] <= h_word[31-8*k -: 8];
            end
        end
    end

    // Assemble read data, lowest byte index in the top bits.
    always_comb begin
        rd_word = {mem[{rd_word_idx, 2'd0}], mem[{rd_word_idx, 2'd1}],
                   mem[{rd_word_idx, 2'd2}], mem[{rd_word_idx, 2'd3}]};
        rd_byte = mem[rd_byte_idx];
    end

    // R10
    host_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_byte_en && ext_we && h_byte_idx == ext_idx)
        |=> mem[$past(h_byte_idx)] == $past(h_byte));
    // R8
    ext_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_we && !h_word_en && !(h_byte_en && h_byte_idx == ext_idx))
        |=> mem[$past(ext_idx)] == $past(ext_byte));
endmodule

// File: rtl/romram_ctrl.sv
// Link controller: shifts in headers, sequences ack, streams reads, collects writes.
// Assumes the host never overlaps a new header with an ongoing transfer.
module romram_ctrl
    import romram_resp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_bit,
    input  logic               hs_done,
    input  logic [31:0]        rom_word,
    input  logic [31:0]        ram_word,
    input  logic [7:0]         rd_byte,
    output logic [WADDR_W-1:0] waddr,
    output logic [BIDX_W-1:0]  byte_idx,
    output logic               h_word_en,
    output logic [31:0]        h_word,
    output logic               h_byte_en,
    output logic [7:0]         h_byte,
    output logic               ack,
    output logic               out_valid,
    output logic               out_bit
);
    localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(31);
    localparam logic [CNT_W-1:0] IMG_LAST  = CNT_W'(IMG_BITS - 1);

    st_e              st;
    op_e              op;
    logic [CNT_W-1:0] cnt;
    logic [10:0]      hdr;
    logic [31:0]      shreg;
    logic [11:0]      hdr_full;
    logic             is_img, is_rd, is_ram;
    logic [CNT_W-1:0] last_cnt;
    logic [31:0]      sel_word;

    // Decode the current transfer kind and target.
    always_comb begin
        hdr_full = {hdr, in_bit};
        is_img   = (op == OP_RD_IMG) || (op == OP_WR_IMG);
        is_rd    = (op == OP_RD_IMG) || (op == OP_RD_WORD);
        is_ram   = (waddr[8:4] == RAM_TAG);
        last_cnt = is_img ? IMG_LAST : WORD_LAST;
        sel_word = is_ram ? ram_word : rom_word;
    end

    // Main sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_HDR;
            op    <= OP_RD_WORD;
            cnt   <= '0;
            hdr   <= '0;
            waddr <= '0;
            shreg <= '0;
        end else begin
            case (st)
                ST_HDR: if (in_valid) begin
                    hdr <= hdr_full[10:0];
                    if (cnt == HDR_LAST) begin
                        cnt <= '0;
                        if (!hdr_full[11]) begin
                            op    <= op_e'(hdr_full[11:9]);
                            waddr <= hdr_full[8:0];
                            st    <= (op_e'(hdr_full[11:9]) == OP_RD_IMG) ? ST_WAIT : ST_ACK;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_WAIT: if (hs_done) st <= ST_ACK;
                ST_ACK: begin
                    cnt <= '0;
                    st  <= is_rd ? ST_TX : ST_RX;
                end
                ST_TX: begin
                    if (cnt == last_cnt) begin
                        cnt <= '0;
                        st  <= ST_HDR;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_RX: if (in_valid) begin
                    shreg <= {shreg[30:0], in_bit};
                    if (cnt == last_cnt) begin
                        cnt <= '0;
                        st  <= ST_HDR;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= ST_HDR;
            endcase
        end
    end

    // Output strobes, serial data and RAM write requests.
    always_comb begin
        ack       = (st == ST_ACK);
        out_valid = (st == ST_TX);
        byte_idx  = cnt[CNT_W-1:3];
        out_bit   = is_img ? rd_byte[~cnt[2:0]] : sel_word[~cnt[4:0]];
        h_word    = {shreg[30:0], in_bit};
        h_byte    = {shreg[6:0], in_bit};
        h_word_en = (st == ST_RX) && in_valid && (op == OP_WR_WORD)
                    && (cnt == WORD_LAST) && is_ram;
        h_byte_en = (st == ST_RX) && in_valid && (op == OP_WR_IMG)
                    && (cnt[2:0] == 3'd7);
    end

    // R3
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    // R3
    ack_tx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack && out_valid));
    // R7
    tx_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(ack));
    // R7
    wait_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT && !hs_done) |=> !ack);
endmodule

// File: rtl/romram_responder.sv
// Top: serial responder for a boot ROM and a 64-byte scratch RAM.
// Assumes a single host on the link and a device engine on the side port.
module romram_responder
    import romram_resp_pkg::*;
#(
    parameter int          ROM_WORDS = 16,
    parameter logic [31:0] ROM_SEED  = 32'h1357_9BDF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       in_bit,
    input  logic       hs_done,
    input  logic       lock_rom,
    input  logic       ext_we,
    input  logic [5:0] ext_idx,
    input  logic [7:0] ext_byte,
    output logic       ack,
    output logic       out_valid,
    output logic       out_bit
);
    logic [WADDR_W-1:0] waddr;
    logic [BIDX_W-1:0]  byte_idx;
    logic [31:0]        rom_word, ram_word, h_word;
    logic [7:0]         rd_byte, h_byte;
    logic               h_word_en, h_byte_en;

    romram_ctrl u_ctrl (
        .clk, .rst_n, .in_valid, .in_bit, .hs_done,
        .rom_word, .ram_word, .rd_byte,
        .waddr, .byte_idx, .h_word_en, .h_word, .h_byte_en, .h_byte,
        .ack, .out_valid, .out_bit
    );

    romram_rom #(.ROM_WORDS(ROM_WORDS), .ROM_SEED(ROM_SEED)) u_rom (
        .clk, .rst_n, .lock_rom, .waddr, .rom_word
    );

    romram_ram u_ram (
        .clk, .rst_n,
        .h_word_en, .h_word_idx(waddr[3:0]), .h_word,
        .h_byte_en, .h_byte_idx(byte_idx), .h_byte,
        .ext_we, .ext_idx, .ext_byte,
        .rd_word_idx(waddr[3:0]), .rd_word(ram_word),
        .rd_byte_idx(byte_idx), .rd_byte
    );
endmodule

// File: tb/sim_romram_responder.sv
module sim_romram_responder;
    localparam int CLK_PERIOD = 10;
    localparam int ROM_WORDS = 16;
    localparam logic [31:0] ROM_SEED = 32'h1357_9BDF;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 0, in_bit = 0, hs_done = 0, lock_rom = 0, ext_we = 0;
    logic [5:0] ext_idx = 0;
    logic [7:0] ext_byte = 0;
    logic ack, out_valid, out_bit;

    int checks = 0, passed = 0;
    bit done = 0;
    logic [7:0] model [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    romram_responder #(.ROM_WORDS(ROM_WORDS), .ROM_SEED(ROM_SEED)) u0 (
        .clk, .rst_n, .in_valid, .in_bit, .hs_done, .lock_rom,
        .ext_we, .ext_idx, .ext_byte, .ack, .out_valid, .out_bit
    );

    function automatic logic [31:0] rom_exp(int i);
        return (i < ROM_WORDS) ? (ROM_SEED ^ (32'(i) * 32'h9E37_79B9)) : 32'h0;
    endfunction

    function automatic logic [31:0] ram_exp(int w);
        return {model[4*w], model[4*w+1], model[4*w+2], model[4*w+3]};
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (ok) passed++;
        else $display("FAIL %s actual=%h expected=%h", req, act, exp);
    endtask

    task automatic send_hdr(logic [2:0] op, logic [8:0] wa);
        logic [11:0] h = {op, wa};
        for (int i = 11; i >= 0; i--) begin
            @(negedge clk); in_valid = 1; in_bit = h[i];
        end
        @(negedge clk); in_valid = 0;
    endtask

    task automatic rd_word(logic [8:0] wa, output logic [31:0] w, output bit got_ack, output bit strobes_ok);
        send_hdr(3'b011, wa);
        got_ack = ack; w = 0; strobes_ok = 1;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            if (!out_valid) strobes_ok = 0;
            w = {w[30:0], out_bit};
        end
    endtask

    task automatic wr_word(logic [8:0] wa, logic [31:0] w, output bit got_ack);
        send_hdr(3'b010, wa);
        got_ack = ack;
        for (int i = 31; i >= 0; i--) begin
            @(negedge clk); in_valid = 1; in_bit = w[i];
        end
        @(negedge clk); in_valid = 0;
    endtask

    task automatic t_reset;
        check(ack == 0 && out_valid == 0, "R12 reset outputs", {ack, out_valid}, 0);
    endtask

    task automatic t_rom_reads;
        logic [31:0] w; bit a, s;
        rd_word(9'd0, w, a, s);
        check(a && s, "R1 R3 ack and strobes on word read", {a, s}, 2'b11);
        check(w == rom_exp(0), "R4 rom word 0", w, rom_exp(0));
        rd_word(9'd5, w, a, s);
        check(w == rom_exp(5), "R4 rom word 5", w, rom_exp(5));
        rd_word(9'd15, w, a, s);
        check(w == rom_exp(15), "R4 rom word 15", w, rom_exp(15));
        rd_word(9'd100, w, a, s);
        check(w == 0, "R4 rom word beyond table", w, 0);
        rd_word(9'h1F3, w, a, s);
        check(w == 0, "R12 ram cleared after reset", w, 0);
    endtask

    task automatic t_word_writes;
        logic [31:0] w; bit a, s;
        wr_word(9'h1F2, 32'hA1B2_C3D4, a);
        model[8] = 8'hA1; model[9] = 8'hB2; model[10] = 8'hC3; model[11] = 8'hD4;
        check(a, "R6 ack on ram write", a, 1);
        rd_word(9'h1F2, w, a, s);
        check(w == 32'hA1B2_C3D4, "R2 R6 ram word readback", w, 32'hA1B2_C3D4);
        wr_word(9'd3, 32'hDEAD_BEEF, a);
        check(a, "R6 ack on rom-region write", a, 1);
        rd_word(9'd3, w, a, s);
        check(w == rom_exp(3), "R6 rom unchanged by write", w, rom_exp(3));
    endtask

    task automatic t_img_write;
        logic [31:0] w; bit a, s;
        logic [7:0] img [64];
        for (int b = 0; b < 64; b++) img[b] = 8'(b * 7 + 3);
        send_hdr(3'b000, 9'h1F0);
        check(ack == 1, "R9 ack on image write", ack, 1);
        for (int i = 0; i < 512; i++) begin
            @(negedge clk);
            ext_we = 0;
            in_valid = 1; in_bit = img[i/8][7 - (i % 8)];
            if (i == 9*8 + 7) begin ext_we = 1; ext_idx = 6'd9; ext_byte = 8'h5A; end
        end
        @(negedge clk); in_valid = 0; ext_we = 0;
        for (int b = 0; b < 64; b++) model[b] = img[b];
        rd_word(9'h1F0, w, a, s);
        check(w == ram_exp(0), "R9 R2 image bytes 0..3", w, ram_exp(0));
        rd_word(9'h1F2, w, a, s);
        check(w == ram_exp(2), "R10 host wins byte 9 collision", w, ram_exp(2));
        rd_word(9'h1FF, w, a, s);
        check(w == ram_exp(15), "R9 image bytes 60..63", w, ram_exp(15));
    endtask

    task automatic t_img_read;
        bit early = 0, bad = 0;
        logic [7:0] got [64];
        send_hdr(3'b001, 9'h1F0);
        if (ack) early = 1;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            ext_we = 0;
            if (ack || out_valid) early = 1;
            if (c == 1) begin ext_we = 1; ext_idx = 6'd0;  ext_byte = 8'hC7; end
            if (c == 3) begin ext_we = 1; ext_idx = 6'd63; ext_byte = 8'h3E; end
        end
        @(negedge clk); ext_we = 0;
        model[0] = 8'hC7; model[63] = 8'h3E;
        check(!early, "R7 no ack before hs_done", early, 0);
        @(negedge clk); hs_done = 1;
        @(negedge clk); hs_done = 0;
        check(ack == 1, "R7 ack after hs_done", ack, 1);
        for (int i = 0; i < 512; i++) begin
            @(negedge clk);
            if (!out_valid) bad = 1;
            got[i/8][7 - (i % 8)] = out_bit;
        end
        check(!bad, "R7 image strobes", bad, 0);
        for (int b = 0; b < 64; b++)
            if (got[b] !== model[b])
                check(0, "R7 R8 image byte", got[b], model[b]);
        check(got[0] == 8'hC7 && got[63] == 8'h3E, "R8 engine updates in image",
              {got[0], got[63]}, 16'hC73E);
    endtask

    task automatic t_ignored;
        logic [31:0] w; bit a, s, seen = 0;
        send_hdr(3'b110, 9'h1F0);
        for (int c = 0; c < 4; c++) begin
            if (ack || out_valid) seen = 1;
            @(negedge clk);
        end
        check(!seen, "R11 unknown opcode no response", seen, 0);
        @(negedge clk); hs_done = 1;
        @(negedge clk); hs_done = 0;
        for (int c = 0; c < 3; c++) begin
            if (ack || out_valid) seen = 1;
            @(negedge clk);
        end
        check(!seen, "R11 idle hs_done ignored", seen, 0);
        rd_word(9'd1, w, a, s);
        check(a && w == rom_exp(1), "R11 header accepted after ignore", w, rom_exp(1));
    endtask

    task automatic t_lock;
        logic [31:0] w; bit a, s;
        @(negedge clk); lock_rom = 1;
        @(negedge clk); lock_rom = 0;
        rd_word(9'd0, w, a, s);
        check(w == 0, "R5 rom hidden after lock", w, 0);
        rd_word(9'h1F2, w, a, s);
        check(w == ram_exp(2), "R5 ram unaffected by lock", w, ram_exp(2));
        rd_word(9'd7, w, a, s);
        check(w == 0, "R5 lock sticky", w, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", passed, checks);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < 64; b++) model[b] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_rom_reads();
        t_word_writes();
        t_img_write();
        t_img_read();
        t_ignored();
        t_lock();
        done = 1;
        $display("%0d/%0d checks passed", passed, checks);
        $finish;
    end
endmodule